// File: doc/BRIEF.md
# OTP Fuse Word Readout Controller

This controller gives software access to a one-time-programmable fuse array. It offers two ways to read it. The first is a command/result register pair. Software writes a byte offset, an unlock key and a start request in one control word. It then polls the control word until the start bit drops, and finally reads the 32-bit fuse word from the result register. The second is a read-only window, which maps the same fuse contents directly into the register space.

The fuse array is modelled as a ROM whose contents come from a seed parameter. A fuse read through the command path takes a configurable number of clock cycles. The start bit doubles as the busy flag. While a read is in flight, a new command cannot disturb it. Commands without the correct key are dropped. After taking the result, software writes zero to the control word to release the lock.

Top module: `fuse_readout_ctrl`

## Requirements
- R1: After synchronous reset, the control word (byte offset 0x40) and the result register (byte offset 0x60) both read 0x0000_0000.
- R2: A write to 0x40 is accepted only when it is made while idle, has bit 1 set and has key 0xAC in bits 15:8. Once accepted, bit 1 of the control word reads 1 for exactly LATENCY clock cycles after the accepting write edge, and then reads 0.
- R3: When bit 1 clears after an accepted command, 0x60 holds fuse word idx, where idx = offset[7:2] and offset is bits 24:16 of the accepted write. Fuse word idx is SEED ^ (idx * 32'h9E37_79B1), taking the low 32 bits.
- R4: Offset bits 1:0 are ignored. An accepted command with offset bit 8 set (offset 0x100 to 0x1FF, outside the 0x100-byte region) leaves 0x0000_0000 in the result register.
- R5: A write to 0x40 that lacks bit 1, or that carries a key other than 0xAC, starts nothing. Bit 1 stays 0 and the result register keeps its previous value.
- R6: A write to 0x40 while bit 1 is set neither restarts nor redirects the read in flight. The result is still the word for the originally accepted offset. Bits 24:16 and 15:8 read back as last written.
- R7: Writing zero to 0x40 when idle makes the control word read 0x0000_0000, keeps the result, and leaves the controller ready for the next keyed command.
- R8: A read of byte address 0x200 + 4*i (i = 0..63) returns fuse word i.
- R9: Writes to 0x60 and to the window have no effect. Reads of any address other than 0x40, 0x60 and 0x200..0x2FF return zero.
- R10: Control word bits 31:25, 7:2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select for the register port |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write transfer, 0 = read transfer |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data; combinational from paddr |

## Verification
The assertions check three things on every cycle:
- the busy interval lasts exactly LATENCY cycles;
- busy only starts on a keyed start write made while idle, and the latched offset holds steady while busy;
- the result changes only on the cycle busy ends, and an out-of-range offset yields zero.

The bench's scenarios are needed for the rest. They show the fuse values for specific offsets, the read-back of fields written during a busy interval, and the release write. They also cover the window contents, ignored writes to the result register and the window, and zero reads from unmapped addresses.

// File: rtl/fuse_pkg.sv
// Shared constants and the fuse content function for the readout controller.
// Assumes 32-bit data and a byte-addressed register space.
package fuse_pkg;
    localparam int unsigned CTRL_ADDR  = 32'h040;
    localparam int unsigned RES_ADDR   = 32'h060;
    localparam int unsigned WIN_BASE   = 32'h200;
    localparam logic [7:0]  UNLOCK_KEY = 8'hAC;
    localparam int unsigned OFF_LSB    = 16;
    localparam int unsigned OFF_W      = 9;
    localparam int unsigned KEY_LSB    = 8;
    localparam int unsigned GO_BIT     = 1;
    localparam logic [31:0] MIX_CONST  = 32'h9E37_79B1;

    // Content of fuse word idx for a given seed.
    function automatic logic [31:0] fuse_word(input logic [31:0] seed, input int unsigned idx);
        logic [31:0] prod;
        prod = idx * MIX_CONST;
        return seed ^ prod;
    endfunction
endpackage

// File: rtl/fuse_rom.sv
// Parameter-initialised model of the fuse array with two asynchronous read ports:
// port A feeds the command sequencer, port B feeds the direct window.
// Assumes WORDS is a power of two and matches 2**IDX_W.
module fuse_rom #(
    parameter int unsigned WORDS = 64,
    parameter int unsigned IDX_W = 6,
    parameter logic [31:0] SEED  = 32'h5A3C_0F12
) (
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    output logic [31:0]      data_a,
    output logic [31:0]      data_b
);
    logic [31:0] cells [WORDS];

    // Fill each cell from the content function.
    generate
        for (genvar gi = 0; gi < WORDS; gi++) begin : g_cell
            assign cells[gi] = fuse_pkg::fuse_word(SEED, gi);
        end
    endgenerate

    // Port A lookup for the sequencer.
    assign data_a = cells[idx_a];
    // Port B lookup for the window.
    assign data_b = cells[idx_b];
endmodule

// File: rtl/fuse_seq.sv
// Command sequencer: accepts a keyed start while idle, latches the offset,
// waits LATENCY cycles, then loads the result and drops busy in the same edge.
// Offsets with bit 8 set lie outside the fuse region and give a zero result.
// Assumes LATENCY >= 1.
module fuse_seq #(
    parameter int unsigned LATENCY = 8,
    parameter int unsigned OFF_W   = 9,
    parameter int unsigned IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [OFF_W-1:0] req_off,
    input  logic [31:0]      rom_data,
    output logic [IDX_W-1:0] rom_idx,
    output logic             busy,
    output logic [OFF_W-1:0] lat_off,
    output logic [31:0]      result
);
    localparam int unsigned CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] cnt;
    logic             out_of_range;
    logic             unused_off;

    assign out_of_range = lat_off[OFF_W-1];
    assign rom_idx      = lat_off[IDX_W+1:2];
    assign unused_off   = ^lat_off[1:0];

    // Busy flag, latency countdown, latched offset and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            lat_off <= '0;
            result  <= '0;
        end else if (!busy) begin
            if (start_req) begin
                busy    <= 1'b1;
                cnt     <= CNT_LOAD;
                lat_off <= req_off;
            end
        end else if (cnt == '0) begin
            busy   <= 1'b0;
            result <= out_of_range ? 32'h0 : rom_data;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/fuse_regs.sv
// Register slave: decodes writes to the control word, holds its offset and key
// fields, raises a start request for keyed start writes, and muxes read data
// for the control word, result register and direct window.
// Assumes a single-word APB-like transfer; writes take effect on psel&penable&pwrite.
module fuse_regs #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned OFF_W  = 9,
    parameter int unsigned IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic              busy,
    input  logic [31:0]       result,
    input  logic [31:0]       win_data,
    output logic [IDX_W-1:0]  win_idx,
    output logic              start_req,
    output logic [OFF_W-1:0]  req_off,
    output logic [31:0]       prdata
);
    import fuse_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(RES_ADDR);
    localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(WIN_BASE);

    logic [OFF_W-1:0]  off_q;
    logic [7:0]        key_q;
    logic              ctrl_wr;
    logic [7:0]        wr_key;
    logic [ADDR_W-1:0] win_rel;
    logic              win_hit;
    logic [31:0]       ctrl_view;
    logic              unused_bits;

    assign ctrl_wr   = psel && penable && pwrite && (paddr == A_CTRL);
    assign wr_key    = pwdata[KEY_LSB +: 8];
    assign req_off   = pwdata[OFF_LSB +: OFF_W];
    assign start_req = ctrl_wr && pwdata[GO_BIT] && (wr_key == UNLOCK_KEY);

    assign win_rel = paddr - A_WIN;
    assign win_hit = (paddr >= A_WIN) && (win_rel[ADDR_W-1:IDX_W+2] == '0);
    assign win_idx = win_rel[IDX_W+1:2];

    assign unused_bits = ^{pwdata[31:OFF_LSB+OFF_W], pwdata[KEY_LSB-1:GO_BIT+1],
                           pwdata[0], win_rel[1:0]};

    // Offset and key fields always follow the last control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            key_q <= '0;
        end else if (ctrl_wr) begin
            off_q <= req_off;
            key_q <= wr_key;
        end
    end

    // Assemble the control word view: fields plus the live busy flag.
    always_comb begin
        ctrl_view = '0;
        ctrl_view[OFF_LSB +: OFF_W] = off_q;
        ctrl_view[KEY_LSB +: 8]     = key_q;
        ctrl_view[GO_BIT]           = busy;
    end

    // Read data mux; unmapped addresses read zero.
    always_comb begin
        if (paddr == A_CTRL) begin
            prdata = ctrl_view;
        end else if (paddr == A_RES) begin
            prdata = result;
        end else if (win_hit) begin
            prdata = win_data;
        end else begin
            prdata = '0;
        end
    end
endmodule

// File: rtl/fuse_readout_ctrl.sv
// Top of the fuse readout controller: register slave, command sequencer and
// fuse array model. Reads go through the command/result pair or the window.
// Assumes ADDR_W >= 10 so the window base is addressable.
module fuse_readout_ctrl #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned LATENCY = 8,
    parameter int unsigned WORDS   = 64,
    parameter logic [31:0] SEED    = 32'h5A3C_0F12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata
);
    localparam int unsigned IDX_W = $clog2(WORDS);
    localparam int unsigned OFF_W = fuse_pkg::OFF_W;

    logic             start_req;
    logic [OFF_W-1:0] req_off;
    logic             busy;
    logic [OFF_W-1:0] lat_off;
    logic [31:0]      result;
    logic [IDX_W-1:0] rom_idx;
    logic [IDX_W-1:0] win_idx;
    logic [31:0]      rom_data;
    logic [31:0]      win_data;

    fuse_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .busy(busy), .result(result),
        .win_data(win_data), .win_idx(win_idx), .start_req(start_req),
        .req_off(req_off), .prdata(prdata)
    );

    fuse_seq #(.LATENCY(LATENCY), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .req_off(req_off),
        .rom_data(rom_data), .rom_idx(rom_idx), .busy(busy), .lat_off(lat_off),
        .result(result)
    );

    fuse_rom #(.WORDS(WORDS), .IDX_W(IDX_W), .SEED(SEED)) u_rom (
        .idx_a(rom_idx), .idx_b(win_idx), .data_a(rom_data), .data_b(win_data)
    );
endmodule

// File: rtl/fuse_readout_chk.sv
// Assertion checker for the fuse readout controller, bound to the top.
// Assumes a synchronous active-low reset on rst_n.
module fuse_readout_chk #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned LATENCY = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              busy,
    input logic [8:0]        lat_off,
    input logic [31:0]       result
);
    localparam int unsigned CW = $clog2(LATENCY + 2);

    logic [CW-1:0] busy_cnt;
    logic          key_start;
    logic          mapped;

    assign key_start = psel && penable && pwrite && (paddr == ADDR_W'(12'h040))
                       && pwdata[1] && (pwdata[15:8] == 8'hAC);
    assign mapped = (paddr == ADDR_W'(12'h040)) || (paddr == ADDR_W'(12'h060))
                    || ((paddr >= ADDR_W'(12'h200)) && (paddr < ADDR_W'(12'h300)));

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CW'(LATENCY)));
    p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CW'(LATENCY)));
    p_start_keyed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(key_start));
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));
    p_offset_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lat_off));
    p_oor_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && lat_off[8]) |-> (result == 32'h0));
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !mapped) |-> (prdata == 32'h0));
endmodule

bind fuse_readout_ctrl fuse_readout_chk #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .busy(busy),
    .lat_off(lat_off), .result(result)
);

// File: tb/test_fuse_readout_ctrl.sv
// Self-checking bench: a vector table of commands walked by one loop, then
// directed tests for reset, busy writes, release, window and ignored accesses.
module test_fuse_readout_ctrl;
    localparam int unsigned LAT  = 8;
    localparam logic [31:0] SEED = 32'h5A3C_0F12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;

    int n_cmp = 0;
    int n_bad = 0;

    fuse_readout_ctrl #(.ADDR_W(12), .LATENCY(LAT), .WORDS(64), .SEED(SEED)) i_fuse_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [8:0] off;
        logic [7:0] key;
        logic       go;
        logic       acc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{9'h000, 8'hAC, 1'b1, 1'b1},
        '{9'h004, 8'hAC, 1'b1, 1'b1},
        '{9'h040, 8'hAB, 1'b1, 1'b0},
        '{9'h0FC, 8'hAC, 1'b1, 1'b1},
        '{9'h0AB, 8'hAC, 1'b1, 1'b1},
        '{9'h080, 8'hAC, 1'b0, 1'b0},
        '{9'h100, 8'hAC, 1'b1, 1'b1},
        '{9'h1FC, 8'hAC, 1'b1, 1'b1},
        '{9'h07C, 8'hAC, 1'b1, 1'b1},
        '{9'h07C, 8'h2C, 1'b1, 1'b0}
    };

    // Expected fuse result for a byte offset (R3, R4).
    function automatic logic [31:0] exp_word(input logic [8:0] off);
        logic [31:0] idx;
        idx = {26'd0, off[7:2]};
        if (off[8]) return 32'h0;
        return SEED ^ (idx * 32'h9E37_79B1);
    endfunction

    function automatic logic [31:0] ctrl_val(input logic [8:0] off, input logic [7:0] key, input logic go);
        return {7'd0, off, key, 6'd0, go, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Write a command, then watch bit 1 every cycle and count busy cycles.
    task automatic run_cmd(input logic [31:0] w, output int cycles);
        logic [31:0] v;
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h040; pwdata = w; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        pwrite = 1'b0;
        cycles = 0;
        #1 v = prdata;
        while (v[1] && cycles < 1000) begin
            cycles++;
            @(negedge clk);
            #1 v = prdata;
        end
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin : main
        logic [31:0] rd;
        logic [31:0] last;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_rd(12'h040, rd); check("R1 ctrl after reset", rd, 32'h0);
        bus_rd(12'h060, rd); check("R1 result after reset", rd, 32'h0);

        // Vector table: R2 busy length, R3/R4 result, R5 ignored commands
        last = 32'h0;
        for (int i = 0; i < NV; i++) begin
            run_cmd(ctrl_val(VEC[i].off, VEC[i].key, VEC[i].go), cyc);
            check(VEC[i].acc ? "R2 busy cycles" : "R5 no busy on ignored", cyc, VEC[i].acc ? LAT : 0);
            if (VEC[i].acc) last = exp_word(VEC[i].off);
            bus_rd(12'h060, rd);
            check(VEC[i].acc ? (VEC[i].off[8] ? "R4 out of range result" : "R3 result word")
                             : "R5 result kept", rd, last);
            bus_wr(12'h040, 32'h0);
        end

        // R6: write during busy
        bus_wr(12'h040, ctrl_val(9'h014, 8'hAC, 1'b1));
        bus_wr(12'h040, ctrl_val(9'h030, 8'hAC, 1'b1));
        bus_rd(12'h040, rd);
        check("R6 fields during busy", rd, ctrl_val(9'h030, 8'hAC, 1'b1));
        for (int k = 0; k < 20; k++) begin
            bus_rd(12'h040, rd);
            if (!rd[1]) break;
        end
        check("R6 busy cleared", {31'd0, rd[1]}, 32'h0);
        bus_rd(12'h060, rd);
        check("R6 original offset result", rd, exp_word(9'h014));

        // R7: release write
        bus_wr(12'h040, 32'h0);
        bus_rd(12'h040, rd); check("R7 ctrl after release", rd, 32'h0);
        bus_rd(12'h060, rd); check("R7 result kept", rd, exp_word(9'h014));
        run_cmd(ctrl_val(9'h038, 8'hAC, 1'b1), cyc);
        check("R7 next command busy", cyc, LAT);
        bus_rd(12'h060, rd); check("R7 next command result", rd, exp_word(9'h038));
        bus_wr(12'h040, 32'h0);

        // R8: direct window
        for (int i = 0; i < 64; i++) begin
            bus_rd(12'h200 + 12'(4 * i), rd);
            check("R8 window word", rd, exp_word(9'(4 * i)));
        end

        // R9: ignored writes and unmapped reads
        bus_wr(12'h060, 32'hDEAD_BEEF);
        bus_rd(12'h060, rd); check("R9 result write ignored", rd, exp_word(9'h038));
        bus_wr(12'h204, 32'h1234_5678);
        bus_rd(12'h204, rd); check("R9 window write ignored", rd, exp_word(9'h004));
        bus_rd(12'h000, rd); check("R9 unmapped 0x000", rd, 32'h0);
        bus_rd(12'h044, rd); check("R9 unmapped 0x044", rd, 32'h0);
        bus_rd(12'h1FC, rd); check("R9 unmapped 0x1FC", rd, 32'h0);
        bus_rd(12'h300, rd); check("R9 unmapped 0x300", rd, 32'h0);
        bus_rd(12'hFFC, rd); check("R9 unmapped 0xFFC", rd, 32'h0);

        // R10: reserved control bits read zero (key 0xFF does not start)
        bus_wr(12'h040, 32'hFFFF_FFFF);
        bus_rd(12'h040, rd); check("R10 reserved bits zero", rd, 32'h01FF_FF00);
        bus_rd(12'h060, rd); check("R10 result unchanged", rd, exp_word(9'h038));
        bus_wr(12'h040, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule